// File: doc/BRIEF.md
# PCIe Memory-Write DMA Packet Generator

This block is the transmit side of a bus-master DMA write engine in a PCIe endpoint. Software loads a 64-bit destination bus address and a transfer length in bytes through a four-entry write-only register port. It then writes a start bit. The engine cuts the transfer into posted memory-write transaction layer packets. Each packet holds at most the maximum payload of 128 bytes and never crosses a 4 KiB address boundary.

Each packet leaves as a header followed by payload dwords, one 32-bit dword per beat, on a valid/ready stream with start-of-packet and end-of-packet markers. The payload is a test pattern: the dword index within the packet, modulo 32, so the pattern starts again at zero in every packet. The header uses the three-dword form when the packet's address fits in 32 bits and the four-dword form otherwise. The requester ID comes from an input.

Top module: `pwd_mwr_dma`

## Requirements
- R1: A register write with `cfg_sel` 0, 1 or 2 loads the low address word, the high address word or the byte length (low `LEN_W` bits of `cfg_wdata`). A write with `cfg_sel` 3 and `cfg_wdata[0]`=1 requests a start. An accepted start raises `busy` and `tx_valid` on the next clock edge. The address and length are copied at that edge.
- R2: A start request is ignored while `busy` is high, and also when the length is zero or not a multiple of 4. An ignored request leaves `busy` and `tx_valid` low, and it does not disturb a transfer in progress.
- R3: Each packet carries min(remaining dwords, 32, dwords left before the next 4 KiB address boundary) payload dwords.
- R4: Header dword 0 is {fmt, 5'b00000, 14'b0, length}. fmt is 3'b011 (four-dword header) when address bits 63:32 of the packet are nonzero, and 3'b010 (three-dword header) otherwise. The 10-bit length field counts dwords.
- R5: Header dword 1 is {requester ID, tag 8'h00, last byte enable, first byte enable 4'hF}. The last byte enable is 4'h0 for a one-dword packet and 4'hF otherwise.
- R6: In the four-dword form, header dwords 2 and 3 are address bits 63:32 and 31:0. In the three-dword form, dword 2 is address bits 31:0. The address of each packet equals the base plus the bytes sent in earlier packets, with carry into the upper word.
- R7: Payload dword i of every packet equals i mod 32.
- R8: `tx_sop` marks header dword 0 and `tx_eop` marks the last payload dword. While `tx_valid` is high and `tx_ready` is low, data and markers stay unchanged.
- R9: Out of reset, `busy`, `done` and `tx_valid` are low. On the edge that accepts the final beat, `busy` falls and `done` pulses high for exactly one cycle.
- R10: Within a transfer, `tx_valid` stays high with no idle cycle between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 addr low, 1 addr high, 2 length, 3 control |
| cfg_wdata | input | 32 | Register write data |
| req_id | input | 16 | Requester ID placed in header dword 1 |
| tx_data | output | 32 | Stream dword |
| tx_valid | output | 1 | Stream beat valid |
| tx_sop | output | 1 | First header dword of a packet |
| tx_eop | output | 1 | Last payload dword of a packet |
| tx_ready | input | 1 | Sink accepts the beat on this edge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
`busy` and the first header beat appear one edge after the start write is registered. Each further beat is presented one edge after the handshake on the previous beat. `done` is high in the cycle that follows the edge consuming the final beat, and low again one edge later. The bench drives `tx_ready` and the register port at the falling edge and samples outputs there. A beat counts as accepted when valid is seen together with the ready value just driven. The expected stream is computed from an arithmetic model that advances only on those accepted beats, so any stall pattern keeps the model in step. `done`, `busy` and the absence of a restarted transfer are checked at the first and second falling edges after the final beat.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
package pwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2
    } pwd_state_e;

    localparam logic [2:0] FMT_HDR3_DATA = 3'b010;
    localparam logic [2:0] FMT_HDR4_DATA = 3'b011;
    localparam logic [4:0] TYPE_MEM      = 5'b00000;
endpackage

// File: rtl/pwd_regs.sv
`timescale 1ns/1ps
module pwd_regs #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output logic [63:0]      base,
    output logic [LEN_W-1:0] len,
    output logic             go
);
    typedef struct packed {
        logic [31:0]      lo;
        logic [31:0]      hi;
        logic [LEN_W-1:0] len;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                2'd0:    r_d.lo  = wdata;
                2'd1:    r_d.hi  = wdata;
                2'd2:    r_d.len = wdata[LEN_W-1:0];
                default: r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base = {r_q.hi, r_q.lo};
    assign len  = r_q.len;
    assign go   = we && (sel == 2'd3) && wdata[0];
endmodule

// File: rtl/pwd_split.sv
`timescale 1ns/1ps
module pwd_split #(
    parameter int MPS_DW = 32,
    parameter int DW_W   = 14,
    parameter int PL_W   = 6
) (
    input  logic [9:0]      addr_dw,
    input  logic [DW_W-1:0] rem,
    output logic [PL_W-1:0] plen
);
    logic [31:0] room, m;

    always_comb begin
        room = 32'd1024 - 32'(addr_dw);
        m    = 32'(rem);
        if (room < m)           m = room;
        if (32'(MPS_DW) < m)    m = 32'(MPS_DW);
        plen = PL_W'(m);
    end
endmodule

// File: rtl/pwd_hdr.sv
`timescale 1ns/1ps
module pwd_hdr #(
    parameter int         PL_W = 6,
    parameter logic [7:0] TAG  = 8'h00
) (
    input  logic            wide,
    input  logic [PL_W-1:0] plen,
    input  logic [15:0]     req_id,
    input  logic [63:0]     addr,
    input  logic [1:0]      idx,
    output logic [31:0]     word
);
    import pwd_pkg::*;

    logic [9:0] len_fld;
    logic [3:0] last_be;

    always_comb begin
        len_fld = 10'(plen);
        last_be = (plen == PL_W'(1)) ? 4'h0 : 4'hF;
        case (idx)
            2'd0:    word = {(wide ? FMT_HDR4_DATA : FMT_HDR3_DATA), TYPE_MEM, 14'd0, len_fld};
            2'd1:    word = {req_id, TAG, last_be, 4'hF};
            2'd2:    word = wide ? addr[63:32] : addr[31:0];
            default: word = addr[31:0];
        endcase
    end
endmodule

// File: rtl/pwd_mwr_dma.sv
`timescale 1ns/1ps
module pwd_mwr_dma #(
    parameter int         MPS_BYTES = 128,
    parameter int         LEN_W     = 16,
    parameter int         PAT_DW    = 32,
    parameter logic [7:0] TAG       = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [15:0] req_id,
    output logic [31:0] tx_data,
    output logic        tx_valid,
    output logic        tx_sop,
    output logic        tx_eop,
    input  logic        tx_ready,
    output logic        busy,
    output logic        done
);
    import pwd_pkg::*;

    localparam int MPS_DW = MPS_BYTES / 4;
    localparam int DW_W   = LEN_W - 2;
    localparam int PL_W   = $clog2(MPS_DW + 1);

    typedef struct packed {
        pwd_state_e      st;
        logic [63:0]     addr;
        logic [DW_W-1:0] rem;
        logic [PL_W-1:0] bi;
        logic            busy;
        logic            done;
    } eng_t;

    eng_t n_d, e_q;

    logic [63:0]      base;
    logic [LEN_W-1:0] len_cfg;
    logic             go, len_ok, wide, fire, last_hdr, last_dat;
    logic [PL_W-1:0]  plen;
    logic [31:0]      hdr_word, pat_word;

    pwd_regs #(.LEN_W(LEN_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .base(base), .len(len_cfg), .go(go)
    );

    pwd_split #(.MPS_DW(MPS_DW), .DW_W(DW_W), .PL_W(PL_W)) i_split (
        .addr_dw(e_q.addr[11:2]), .rem(e_q.rem), .plen(plen)
    );

    pwd_hdr #(.PL_W(PL_W), .TAG(TAG)) i_hdr (
        .wide(wide), .plen(plen), .req_id(req_id), .addr(e_q.addr),
        .idx(e_q.bi[1:0]), .word(hdr_word)
    );

    always_comb begin
        len_ok   = (len_cfg != '0) && (len_cfg[1:0] == 2'b00);
        wide     = |e_q.addr[63:32];
        fire     = tx_valid && tx_ready;
        last_hdr = e_q.bi == (wide ? PL_W'(3) : PL_W'(2));
        last_dat = e_q.bi == plen - PL_W'(1);
        pat_word = 32'(e_q.bi) % 32'(PAT_DW);

        n_d      = e_q;
        n_d.done = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (go && len_ok) begin
                    n_d.st   = ST_HDR;
                    n_d.addr = base;
                    n_d.rem  = len_cfg[LEN_W-1:2];
                    n_d.bi   = '0;
                    n_d.busy = 1'b1;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (last_hdr) begin
                        n_d.st = ST_DATA;
                        n_d.bi = '0;
                    end else begin
                        n_d.bi = e_q.bi + PL_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (fire && last_dat) begin
                    n_d.addr = e_q.addr + {{(62-PL_W){1'b0}}, plen, 2'b00};
                    n_d.rem  = e_q.rem - DW_W'(plen);
                    n_d.bi   = '0;
                    if (e_q.rem == DW_W'(plen)) begin
                        n_d.st   = ST_IDLE;
                        n_d.busy = 1'b0;
                        n_d.done = 1'b1;
                    end else begin
                        n_d.st = ST_HDR;
                    end
                end else if (fire) begin
                    n_d.bi = e_q.bi + PL_W'(1);
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_IDLE;
        end else begin
            e_q      <= n_d;
        end
    end

    assign tx_valid = e_q.st != ST_IDLE;
    assign tx_sop   = (e_q.st == ST_HDR) && (e_q.bi == '0);
    assign tx_eop   = (e_q.st == ST_DATA) && last_dat;
    assign tx_data  = (e_q.st == ST_HDR) ? hdr_word : pat_word;
    assign busy     = e_q.busy;
    assign done     = e_q.done;

    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

    assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_eop |=> (tx_valid && tx_sop) || done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !tx_valid);

    assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_split_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (plen != '0) && (32'(plen) <= 32'(MPS_DW))
                     && (32'(e_q.addr[11:0]) + (32'(plen) << 2) <= 32'd4096));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && go && !(tx_valid && tx_ready && tx_eop) |=> busy);
endmodule

// File: tb/test_pwd_mwr_dma.sv
`timescale 1ns/1ps
module test_pwd_mwr_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [15:0] req_id = 16'h0100;
    logic [31:0] tx_data;
    logic        tx_valid, tx_sop, tx_eop, busy, done;
    logic        tx_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [63:0] e_addr;
    int          e_rem, e_pl, e_bi, e_hn;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwd_mwr_dma i_pwd_mwr_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_id(req_id), .tx_data(tx_data), .tx_valid(tx_valid), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_ready(tx_ready), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int pl_of(input logic [63:0] a, input int rem);
        int room, m;
        room = 1024 - int'(a[11:2]);
        m = rem;
        if (room < m) m = room;
        if (32 < m) m = 32;
        return m;
    endfunction

    function automatic logic [31:0] exp_word();
        logic [9:0] lf;
        lf = 10'(e_pl);
        if (e_bi == 0) return {(e_hn == 4) ? 3'b011 : 3'b010, 5'b0, 14'd0, lf};
        if (e_bi == 1) return {req_id, 8'h00, (e_pl == 1) ? 4'h0 : 4'hF, 4'hF};
        if (e_bi == 2) return (e_hn == 4) ? e_addr[63:32] : e_addr[31:0];
        if (e_bi == 3 && e_hn == 4) return e_addr[31:0];
        return 32'((e_bi - e_hn) % 32);
    endfunction

    function automatic string req_of();
        if (e_bi == 0) return "R4";
        if (e_bi == 1) return "R5";
        if (e_bi < e_hn) return "R6";
        return "R7";
    endfunction

    function automatic bit rdy_pat(input int mode, input int c);
        if (mode == 1) return (c % 3) != 0;
        if (mode == 2) return ((c * 5 + 1) % 7) < 4;
        return 1'b1;
    endfunction

    task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic [63:0] base, input int len, input int mode, input int poke_at);
        int  guard, beats;
        bit  prev_stall;
        logic [31:0] prev_data;
        bit  r;
        reg_wr(2'd0, base[31:0]);
        reg_wr(2'd1, base[63:32]);
        reg_wr(2'd2, 32'(len));
        reg_wr(2'd3, 32'd1);
        chk(busy === 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
        e_addr = base; e_rem = len / 4; e_bi = 0;
        e_pl = pl_of(e_addr, e_rem);
        e_hn = (e_addr[63:32] != 0) ? 4 : 3;
        guard = 0; beats = 0; prev_stall = 0; prev_data = '0;
        while (e_rem > 0 && guard < 20000) begin
            r = rdy_pat(mode, cyc);
            tx_ready = r;
            if (beats == poke_at) begin
                cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'd1;
            end else begin
                cfg_we = 1'b0;
            end
            chk(tx_valid === 1'b1, "R10", "valid within transfer", 64'(tx_valid), 64'd1);
            if (prev_stall)
                chk(tx_data === prev_data, "R8", "data held under stall", 64'(tx_data), 64'(prev_data));
            if (tx_valid && r) begin
                chk(tx_data === exp_word(), req_of(), "dword", 64'(tx_data), 64'(exp_word()));
                chk({tx_sop, tx_eop} === {e_bi == 0, e_bi == e_hn + e_pl - 1}, "R8", "sop/eop",
                    64'({tx_sop, tx_eop}), 64'({e_bi == 0, e_bi == e_hn + e_pl - 1}));
                beats++;
                e_bi++;
                if (e_bi == e_hn + e_pl) begin
                    e_addr = e_addr + 64'(e_pl * 4);
                    e_rem  = e_rem - e_pl;
                    e_bi   = 0;
                    if (e_rem > 0) begin
                        e_pl = pl_of(e_addr, e_rem);
                        e_hn = (e_addr[63:32] != 0) ? 4 : 3;
                    end
                end
            end
            prev_stall = tx_valid && !r;
            prev_data  = tx_data;
            guard++;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(guard < 20000, "R9", "transfer completes", 64'(guard), 64'd0);
        chk({done, busy, tx_valid} === 3'b100, "R9", "done/busy/valid at end",
            64'({done, busy, tx_valid}), 64'(3'b100));
        @(negedge clk);
        chk({done, busy, tx_valid} === 3'b000, "R2", "single done, no restart",
            64'({done, busy, tx_valid}), 64'd0);
    endtask

    task automatic bad_start(input int len);
        reg_wr(2'd2, 32'(len));
        reg_wr(2'd3, 32'd1);
        chk({busy, tx_valid} === 2'b00, "R2", "invalid length ignored", 64'({busy, tx_valid}), 64'd0);
        @(negedge clk);
        chk({busy, tx_valid, done} === 3'b000, "R2", "still idle", 64'({busy, tx_valid, done}), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, tx_valid} === 3'b000, "R9", "reset state", 64'({busy, done, tx_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, tx_valid} === 3'b000, "R9", "idle after reset", 64'({busy, done, tx_valid}), 64'd0);

        run_xfer(64'h0000_0000_8000_0000, 4096, 0, -1);   // 32 packets, short header
        run_xfer(64'h0000_0001_8000_0000, 4096, 1, 5);    // long header, start poked while busy
        run_xfer(64'h0000_0000_8000_0FF0, 64, 2, -1);     // 4 KiB boundary split (R3)
        req_id = 16'hA5C3;
        run_xfer(64'h0000_0000_FFFF_FF80, 256, 1, -1);    // carry into upper word (R6)
        run_xfer(64'h0000_0002_0000_0040, 4, 0, -1);      // one-dword packet (R5)
        run_xfer(64'h0000_0000_0000_1000, 132, 2, 40);    // partial final packet (R3)
        run_xfer(64'h0000_0000_0000_0FFC, 8, 1, -1);      // two one-dword packets across boundary
        for (int k = 0; k < 8; k++)
            run_xfer(64'h0000_0000_0000_2000 - 64'(20 * k), 4 * (7 * k + 1), k % 3, -1);
        bad_start(0);
        bad_start(6);
        bad_start(130);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule